// File: doc/BRIEF.md
# Single-Master Handshake Bus Fabric

This fabric connects one processor-side master to twelve memory-mapped slaves over a four-phase request/acknowledge handshake. Write data and read data travel on separate buses, so no tristate drivers are needed.

The master starts a transfer by presenting an address, write data and a read/write flag, and then raising its request. The fabric registers this request. It decodes the top byte of the address into a single slave select, and passes the low byte to all slaves as a local offset. The write data and write flag go to every slave. The selected slave answers with its acknowledge. It can hold that acknowledge back for as long as it needs, which stalls the master.

The fabric picks the acknowledge and read data of the addressed slave through a one-hot multiplexer. It registers both before returning them to the master, so no combinational path runs from the master request to any slave-side output or back. When the address matches no slave, a built-in default responder acknowledges the access and returns zero, so the master never waits forever.

Top module: `hbi_fabric`

## Requirements
- R1: While reset is held, and after it is released with no request, `m_ack` is 0, `s_sel` is all zeros and `m_rdata` is 0x0000.
- R2: For a request whose address top byte has a value k from 0 to 11, `s_sel` carries only bit k from the first clock edge that samples the request until the edge that samples the request low. At no time is more than one select bit high.
- R3: Every slave sees the same `s_addr`, `s_we` and `s_wdata`. These are the low 8 address bits, the write flag (1 = write) and the write data that the master presented when the request was first sampled. They stay stable while a select is high.
- R4: `m_ack` rises on the clock edge that first samples the selected slave's `s_ack` high. A slave that withholds its acknowledge for any number of cycles stalls the master for that long. `m_ack` is never high unless the request or the acknowledge was high on the previous edge.
- R5: On a read (`m_we` = 0), `m_rdata` holds the selected slave's read data from the edge on which `m_ack` rises. It keeps that value through later writes, and until the next read completes.
- R6: On the first clock edge that samples the request low, `s_sel` returns to zero. `m_ack` then falls on the edge that first samples the selected slave's acknowledge low.
- R7: A request whose address top byte is 12 or more selects no slave. It is acknowledged on the second clock edge after the request is first sampled. On a read it returns 0x0000.
- R8: Acknowledges from slaves that are not addressed by the transfer in progress have no effect on `m_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| m_req | input | 1 | Master request |
| m_we | input | 1 | Master write flag, 1 = write |
| m_addr | input | 16 | Master address, top byte picks the slave |
| m_wdata | input | 16 | Master write data |
| m_ack | output | 1 | Registered acknowledge to the master |
| m_rdata | output | 16 | Registered read data to the master |
| s_sel | output | 12 | One select line per slave |
| s_addr | output | 8 | Shared slave local offset |
| s_we | output | 1 | Shared write flag |
| s_wdata | output | 16 | Shared write data |
| s_ack | input | 12 | Acknowledge from each slave |
| s_rdata | input | 192 | Read data of all slaves, slave i at bits 16*i+15 down to 16*i |

## Verification
Two functions can meet in one cycle. One slave is stalling the transfer in progress while a different, unaddressed slave drives its acknowledge high. The return multiplexer must pass the addressed slave's acknowledge and block the other one. The bench provokes this by forcing a stray acknowledge on a neighbouring slave during a long stall, and on slave 0 during an unmapped access, whose default target index is 0. It judges the result by checking that the acknowledge wait seen at the master equals the addressed slave's own delay plus one cycle, or the fixed default responder wait for the unmapped access.

// File: rtl/hbi_pkg.sv
package hbi_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACTIVE  = 2'd1,
        ST_RELEASE = 2'd2
    } hbi_state_e;

endpackage

// File: rtl/hbi_decoder.sv
module hbi_decoder #(
    parameter int ADDR_W   = 16,
    parameter int SEL_BITS = 8,
    parameter int N_SLV    = 12,
    localparam int IDX_W   = $clog2(N_SLV)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);
    localparam logic [SEL_BITS-1:0] LIMIT = SEL_BITS'(N_SLV);

    logic [SEL_BITS-1:0] region;

    always_comb begin
        region = addr[ADDR_W-1 -: SEL_BITS];
        hit    = (region < LIMIT);
        idx    = hit ? region[IDX_W-1:0] : '0;
    end
endmodule

// File: rtl/hbi_default_resp.sv
module hbi_default_resp (
    input  logic clk,
    input  logic rst,
    input  logic miss_active,
    output logic dflt_ack
);
    logic ack_d, ack_q;

    always_comb begin
        ack_d = miss_active;
    end

    always_ff @(posedge clk) begin
        if (rst) ack_q <= 1'b0;
        else     ack_q <= ack_d;
    end

    assign dflt_ack = ack_q;
endmodule

// File: rtl/hbi_return_mux.sv
module hbi_return_mux #(
    parameter int N_SLV  = 12,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(N_SLV)
) (
    input  logic [N_SLV-1:0]        s_ack,
    input  logic [N_SLV*DATA_W-1:0] s_rdata,
    input  logic [IDX_W-1:0]        tgt,
    input  logic                    hit,
    input  logic                    dflt_ack,
    output logic                    tgt_ack,
    output logic [DATA_W-1:0]       tgt_rdata
);
    logic [N_SLV-1:0]  onehot;
    logic              ack_or;
    logic [DATA_W-1:0] data_or;

    genvar g;
    generate
        for (g = 0; g < N_SLV; g++) begin : g_sel
            assign onehot[g] = hit && (tgt == IDX_W'(g));
        end
    endgenerate

    always_comb begin
        ack_or  = 1'b0;
        data_or = '0;
        for (int i = 0; i < N_SLV; i++) begin
            ack_or  = ack_or | (onehot[i] & s_ack[i]);
            data_or = data_or | ({DATA_W{onehot[i]}} & s_rdata[i*DATA_W +: DATA_W]);
        end
        tgt_ack   = hit ? ack_or : dflt_ack;
        tgt_rdata = hit ? data_or : '0;
    end
endmodule

// File: rtl/hbi_ctrl.sv
module hbi_ctrl
    import hbi_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 16,
    parameter int N_SLV   = 12,
    parameter int OFS_W   = 8,
    localparam int IDX_W  = $clog2(N_SLV)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              m_req,
    input  logic              m_we,
    input  logic [ADDR_W-1:0] m_addr,
    input  logic [DATA_W-1:0] m_wdata,
    input  logic              dec_hit,
    input  logic [IDX_W-1:0]  dec_idx,
    input  logic              tgt_ack,
    input  logic [DATA_W-1:0] tgt_rdata,
    output logic              m_ack,
    output logic [DATA_W-1:0] m_rdata,
    output logic [N_SLV-1:0]  s_sel,
    output logic [OFS_W-1:0]  s_addr,
    output logic              s_we,
    output logic [DATA_W-1:0] s_wdata,
    output logic [IDX_W-1:0]  tgt,
    output logic              hit,
    output logic              miss_active
);
    typedef struct packed {
        hbi_state_e        state;
        logic [IDX_W-1:0]  tgt;
        logic              hit;
        logic [OFS_W-1:0]  ofs;
        logic              we;
        logic [DATA_W-1:0] wdata;
        logic              ack;
        logic [DATA_W-1:0] rdata;
    } ctrl_t;

    ctrl_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (r_q.state)
            ST_IDLE: begin
                if (m_req) begin
                    r_d.state = ST_ACTIVE;
                    r_d.tgt   = dec_idx;
                    r_d.hit   = dec_hit;
                    r_d.ofs   = m_addr[OFS_W-1:0];
                    r_d.we    = m_we;
                    r_d.wdata = m_wdata;
                end
            end
            ST_ACTIVE: begin
                if (!m_req) r_d.state = ST_RELEASE;
            end
            ST_RELEASE: begin
                if (!tgt_ack) r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
        r_d.ack = (r_q.state != ST_IDLE) && tgt_ack;
        if ((r_q.state == ST_ACTIVE) && tgt_ack && !r_q.we) begin
            r_d.rdata = tgt_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '{state: ST_IDLE, tgt: '0, hit: 1'b0, ofs: '0, we: 1'b0,
                     wdata: '0, ack: 1'b0, rdata: '0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        for (int i = 0; i < N_SLV; i++) begin
            s_sel[i] = (r_q.state == ST_ACTIVE) && r_q.hit && (r_q.tgt == IDX_W'(i));
        end
        miss_active = (r_q.state == ST_ACTIVE) && !r_q.hit;
    end

    assign m_ack   = r_q.ack;
    assign m_rdata = r_q.rdata;
    assign s_addr  = r_q.ofs;
    assign s_we    = r_q.we;
    assign s_wdata = r_q.wdata;
    assign tgt     = r_q.tgt;
    assign hit     = r_q.hit;
endmodule

// File: rtl/hbi_fabric.sv
module hbi_fabric #(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 16,
    parameter int N_SLV    = 12,
    parameter int SEL_BITS = 8,
    parameter int OFS_W    = 8,
    localparam int IDX_W   = $clog2(N_SLV)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    m_req,
    input  logic                    m_we,
    input  logic [ADDR_W-1:0]       m_addr,
    input  logic [DATA_W-1:0]       m_wdata,
    output logic                    m_ack,
    output logic [DATA_W-1:0]       m_rdata,
    output logic [N_SLV-1:0]        s_sel,
    output logic [OFS_W-1:0]        s_addr,
    output logic                    s_we,
    output logic [DATA_W-1:0]       s_wdata,
    input  logic [N_SLV-1:0]        s_ack,
    input  logic [N_SLV*DATA_W-1:0] s_rdata
);
    logic              dec_hit;
    logic [IDX_W-1:0]  dec_idx;
    logic [IDX_W-1:0]  tgt;
    logic              hit;
    logic              miss_active;
    logic              dflt_ack;
    logic              tgt_ack;
    logic [DATA_W-1:0] tgt_rdata;

    hbi_decoder #(.ADDR_W(ADDR_W), .SEL_BITS(SEL_BITS), .N_SLV(N_SLV)) u_dec (
        .addr(m_addr), .hit(dec_hit), .idx(dec_idx)
    );

    hbi_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_SLV(N_SLV), .OFS_W(OFS_W)) u_ctrl (
        .clk(clk), .rst(rst), .m_req(m_req), .m_we(m_we), .m_addr(m_addr),
        .m_wdata(m_wdata), .dec_hit(dec_hit), .dec_idx(dec_idx),
        .tgt_ack(tgt_ack), .tgt_rdata(tgt_rdata), .m_ack(m_ack),
        .m_rdata(m_rdata), .s_sel(s_sel), .s_addr(s_addr), .s_we(s_we),
        .s_wdata(s_wdata), .tgt(tgt), .hit(hit), .miss_active(miss_active)
    );

    hbi_default_resp u_dflt (
        .clk(clk), .rst(rst), .miss_active(miss_active), .dflt_ack(dflt_ack)
    );

    hbi_return_mux #(.N_SLV(N_SLV), .DATA_W(DATA_W)) u_mux (
        .s_ack(s_ack), .s_rdata(s_rdata), .tgt(tgt), .hit(hit),
        .dflt_ack(dflt_ack), .tgt_ack(tgt_ack), .tgt_rdata(tgt_rdata)
    );
endmodule

// File: rtl/hbi_fabric_chk.sv
module hbi_fabric_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int N_SLV  = 12,
    parameter int OFS_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              m_req,
    input logic              m_ack,
    input logic [DATA_W-1:0] m_rdata,
    input logic [N_SLV-1:0]  s_sel,
    input logic [OFS_W-1:0]  s_addr,
    input logic              s_we,
    input logic [DATA_W-1:0] s_wdata
);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!m_ack && (s_sel == '0)));

    // R2
    sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(s_sel));

    // R3
    shared_stable_chk: assert property (@(posedge clk) disable iff (rst)
        ((|s_sel) && $past(|s_sel)) |-> ($stable(s_addr) && $stable(s_we) && $stable(s_wdata)));

    // R4
    ack_cause_chk: assert property (@(posedge clk) disable iff (rst)
        m_ack |-> ($past(m_req) || $past(m_ack)));

    // R5
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!m_ack && $past(!m_ack)) |-> $stable(m_rdata));

    // R6
    sel_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(m_req) |=> (s_sel == '0));
endmodule

bind hbi_fabric hbi_fabric_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_SLV(N_SLV), .OFS_W(OFS_W)
) u_chk (
    .clk(clk), .rst(rst), .m_req(m_req), .m_ack(m_ack), .m_rdata(m_rdata),
    .s_sel(s_sel), .s_addr(s_addr), .s_we(s_we), .s_wdata(s_wdata)
);

// File: tb/hbi_fabric_bench.sv
module hbi_fabric_bench;
    localparam int NS = 12;
    localparam int DW = 16;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           m_req = 1'b0;
    logic           m_we = 1'b0;
    logic [15:0]    m_addr = '0;
    logic [15:0]    m_wdata = '0;
    logic           m_ack;
    logic [15:0]    m_rdata;
    logic [NS-1:0]  s_sel;
    logic [7:0]     s_addr;
    logic           s_we;
    logic [15:0]    s_wdata;
    logic [NS-1:0]  s_ack;
    logic [NS*DW-1:0] s_rdata;

    logic [NS-1:0]  model_ack = '0;
    logic [NS-1:0]  rogue = '0;
    int             dly [NS];
    int             cnt [NS];
    logic [7:0]     snap_ofs [NS];
    logic [15:0]    snap_wd [NS];
    logic           snap_we [NS];

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [15:0] last_rd = '0;

    always #10 clk = ~clk;

    function automatic logic [15:0] exp_rd(input int i, input logic [7:0] ofs);
        exp_rd = {4'(i), 4'h9, ofs ^ 8'h5A};
    endfunction

    genvar g;
    generate
        for (g = 0; g < NS; g++) begin : g_slv
            assign s_rdata[g*DW +: DW] = exp_rd(g, s_addr);
        end
    endgenerate

    assign s_ack = model_ack | rogue;

    hbi_fabric u_hbi_fabric (
        .clk(clk), .rst(rst), .m_req(m_req), .m_we(m_we), .m_addr(m_addr),
        .m_wdata(m_wdata), .m_ack(m_ack), .m_rdata(m_rdata), .s_sel(s_sel),
        .s_addr(s_addr), .s_we(s_we), .s_wdata(s_wdata), .s_ack(s_ack),
        .s_rdata(s_rdata)
    );

    always @(negedge clk) begin
        for (int i = 0; i < NS; i++) begin
            if (s_sel[i]) begin
                if (!model_ack[i]) begin
                    cnt[i] = cnt[i] + 1;
                    if (cnt[i] >= dly[i]) begin
                        model_ack[i] = 1'b1;
                        snap_ofs[i]  = s_addr;
                        snap_wd[i]   = s_wdata;
                        snap_we[i]   = s_we;
                    end
                end
            end else begin
                model_ack[i] = 1'b0;
                cnt[i] = 0;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic txn(input logic [15:0] addr, input logic we, input logic [15:0] wd,
                       input string req);
        int k;
        bit mapped;
        int n;
        int m;
        logic [NS-1:0] esel;
        k = int'(addr[15:8]);
        mapped = (k < NS);
        esel = mapped ? (NS'(1) << k) : '0;
        @(negedge clk);
        m_addr = addr; m_we = we; m_wdata = wd; m_req = 1'b1;
        @(negedge clk);
        chk(s_sel == esel, "R2", "select", int'(s_sel), int'(esel));
        n = 1;
        while (!m_ack && n < 200) begin
            @(negedge clk);
            n++;
        end
        if (mapped) chk(n == dly[k] + 1, req, "ack wait R4", n, dly[k] + 1);
        else        chk(n == 3, req, "default ack wait R7", n, 3);
        if (mapped) begin
            chk(snap_ofs[k] == addr[7:0] && snap_we[k] == we && snap_wd[k] == wd,
                "R3", "shared fields", int'({snap_we[k], snap_ofs[k], snap_wd[k]}),
                int'({we, addr[7:0], wd}));
        end
        if (!we) begin
            last_rd = mapped ? exp_rd(k, addr[7:0]) : 16'h0000;
            chk(m_rdata == last_rd, mapped ? "R5" : "R7", "read data",
                int'(m_rdata), int'(last_rd));
        end else begin
            chk(m_rdata == last_rd, "R5", "rdata held over write",
                int'(m_rdata), int'(last_rd));
        end
        m_req = 1'b0;
        @(negedge clk);
        chk(s_sel == '0, "R6", "select released", int'(s_sel), 0);
        m = 1;
        while (m_ack && m < 200) begin
            @(negedge clk);
            m++;
        end
        chk(m == (mapped ? 2 : 3), "R6", "ack release wait", m, mapped ? 2 : 3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R4 watchdog expired: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd24681));
        for (int i = 0; i < NS; i++) begin
            dly[i] = 1; cnt[i] = 0;
            snap_ofs[i] = '0; snap_wd[i] = '0; snap_we[i] = 1'b0;
        end
        m_req = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!m_ack && s_sel == '0 && m_rdata == '0, "R1", "state in reset",
            int'({m_ack, s_sel, m_rdata}), 0);
        m_req = 1'b0;
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(!m_ack && s_sel == '0 && m_rdata == '0, "R1", "idle after reset",
            int'({m_ack, s_sel, m_rdata}), 0);

        dly[0] = 1;  txn(16'h0012, 1'b0, 16'h0000, "R4");
        dly[11] = 6; txn(16'h0BFE, 1'b0, 16'h0000, "R4");
        dly[5] = 40; txn(16'h0533, 1'b1, 16'hBEEF, "R4");
        txn(16'h0C05, 1'b0, 16'h0000, "R7");
        txn(16'hFF00, 1'b1, 16'h1234, "R7");
        dly[7] = 2;  txn(16'h0781, 1'b0, 16'h0000, "R5");
        txn(16'h0790, 1'b1, 16'h5555, "R5");

        dly[3] = 10;
        rogue = NS'(1) << 4;
        txn(16'h0344, 1'b0, 16'h0000, "R8");
        rogue = NS'(1);
        txn(16'h2001, 1'b0, 16'h0000, "R8");
        rogue = '0;

        for (int t = 0; t < 60; t++) begin
            logic [15:0] a;
            a = {4'h0, 4'($urandom % 14), 8'($urandom)};
            for (int i = 0; i < NS; i++) dly[i] = 1 + int'($urandom % 8);
            txn(a, 1'($urandom), 16'($urandom), "R4");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule